// File: doc/BRIEF.md
# SPI Flash Block-Erase Command Controller

This block is the device-side command front end of a serial NOR flash, reduced to the part that handles the 64 KB block erase. It watches chip select, serial clock and serial data in from a host. It decodes four commands: write enable, write disable, read status and block erase. It keeps a two-bit status (busy and write-enable latch). When an erase is accepted, it raises a request toward the array erase engine. Here that engine is modelled as a self-timed countdown of a parameterised number of system clock cycles.

The serial inputs are brought into the system clock domain through two-stage synchronisers. Serial clock edges are then found by comparing successive synchronised samples. Input bits are taken on serial clock rising edges and status bits are launched on falling edges. As a result, hosts that idle the clock low (mode 0) and hosts that idle it high (mode 3) are both served. The serial clock must therefore run several times slower than the system clock.

The erase is guarded in three ways. Chip select must rise exactly after the 32nd bit. The write-enable latch must be set. The addressed block must lie outside the region chosen by the protection inputs.

Top module: `spi_blk_erase_ctl`

## Requirements
- R1: After reset the erase request is low, the data-out enable is low, and a status read returns 0x00.
- R2: A frame of exactly 8 bits carrying opcode 0x06 sets the write-enable latch. Opcode 0x04 clears it. The status byte carries busy in bit 0 and the write-enable latch in bit 1, and all other bits are 0.
- R3: After opcode 0x05, the status byte is shifted out MSB first, changing on falling clock edges. It repeats for as long as the clock runs, and each byte reflects the current status. The data-out enable is 1 only in that phase.
- R4: Opcode 0xD8 followed by a 24-bit address, MSB first, starts an erase. The erase request rises and the erase block output shows address bits [16 +: BLK_BITS].
- R5: An erase frame whose chip select rises after any bit count other than 32 (for example 31 or 40) is discarded.
- R6: An erase frame is ignored while the write-enable latch is 0.
- R7: The protection inputs work as follows. bp=0 protects nothing. Otherwise the lowest 2^(bp-1) blocks (tb=1) or the highest 2^(bp-1) blocks (tb=0) are protected, and a count above the block total protects every block. cmp=1 inverts the set. An erase aimed at a protected block is ignored and leaves the write-enable latch set.
- R8: Busy stays 1 for exactly ERASE_CYCLES system clock cycles. When it drops, the write-enable latch is cleared.
- R9: While busy, every command except status read is ignored. A write disable leaves the latch set, and a second erase neither restarts the countdown nor changes the block.
- R10: Mode 0 and mode 3 hosts produce identical results for every command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from host |
| mosi | input | 1 | Serial data from host |
| prot_cmp | input | 1 | Inverts the protected region |
| prot_tb | input | 1 | 1: region counts from the bottom block, 0: from the top |
| prot_bp | input | 3 | Protected region size code |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Drive enable for miso (0 means high impedance) |
| erase_req | output | 1 | High while the self-timed erase runs (busy) |
| erase_blk | output | BLK_BITS | Index of the 64 KB block being erased |

## Verification
The bench aims at frames that end one bit short or one byte long. A controller that decodes on the opcode alone would start an erase for these. It probes the protection region edges from the top and bottom and with the inversion bit. An off-by-one there erases a locked block or refuses a free one. It polls status in the middle of an erase and sends write disable and a second erase during busy. A design that lets commands through while busy would clear the latch or restart the countdown. Finally, it measures the busy length and checks the latch after completion, and runs commands in both clock polarities to catch edge-selection mistakes.

// File: rtl/spi_blk_erase_ctl.sv
module spi_blk_erase_ctl #(
  parameter int ERASE_CYCLES = 200,
  parameter int BLK_BITS     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic                mosi,
  input  logic                prot_cmp,
  input  logic                prot_tb,
  input  logic [2:0]          prot_bp,
  output logic                miso,
  output logic                miso_oe,
  output logic                erase_req,
  output logic [BLK_BITS-1:0] erase_blk
);
  localparam int TW   = $clog2(ERASE_CYCLES + 1);
  localparam int NBLK = 1 << BLK_BITS;
  localparam logic [7:0] OP_WREN = 8'h06, OP_WRDI = 8'h04, OP_RDSR = 8'h05, OP_ERASE = 8'hD8;

  logic [2:0] cs_q, sck_q;
  logic [1:0] mosi_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 3'b111;
      sck_q  <= 3'b000;
      mosi_q <= 2'b00;
    end else begin
      cs_q   <= {cs_q[1:0], cs_n};
      sck_q  <= {sck_q[1:0], sclk};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  wire cs_act   = ~cs_q[1];
  wire cs_fall  = ~cs_q[1] &  cs_q[2];
  wire cs_rise  =  cs_q[1] & ~cs_q[2];
  wire sck_rise =  sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] &  sck_q[2];
  wire mosi_s   = mosi_q[1];

  logic [2:0]  bitcnt, nbytes;
  logic [31:0] word;
  logic [7:0]  op, out_sh;
  logic        busy, wel;
  logic [TW-1:0] timer;
  logic [BLK_BITS-1:0] blk;

  wire rdsr_phase = (op == OP_RDSR) && (nbytes != 3'd0);
  wire [7:0] status = {6'b0, wel, busy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt <= '0;
      nbytes <= '0;
      word   <= '0;
      op     <= '0;
      out_sh <= '0;
    end else if (cs_fall) begin
      bitcnt <= '0;
      nbytes <= '0;
      op     <= '0;
      out_sh <= '0;
    end else if (cs_act) begin
      if (sck_rise) begin
        word   <= {word[30:0], mosi_s};
        bitcnt <= bitcnt + 3'd1;
        if (bitcnt == 3'd7) begin
          if (nbytes != 3'd7) nbytes <= nbytes + 3'd1;
          if (nbytes == 3'd0) op <= {word[6:0], mosi_s};
        end
      end
      if (sck_fall && rdsr_phase)
        out_sh <= (bitcnt == 3'd0) ? status : {out_sh[6:0], 1'b0};
    end
  end

  wire [BLK_BITS-1:0] tgt_blk = word[16 +: BLK_BITS];
  logic prot_hit;
  always_comb begin
    int n;
    logic hit;
    hit = 1'b0;
    n = 0;
    if (prot_bp != 3'd0) begin
      if (int'(prot_bp) - 1 >= BLK_BITS) hit = 1'b1;
      else begin
        n = 1 << (int'(prot_bp) - 1);
        hit = prot_tb ? (int'(tgt_blk) < n) : (int'(tgt_blk) >= NBLK - n);
      end
    end
    prot_hit = hit ^ prot_cmp;
  end

  wire frame_end = cs_rise && (bitcnt == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      wel   <= 1'b0;
      timer <= '0;
      blk   <= '0;
    end else if (busy) begin
      if (timer == '0) begin
        busy <= 1'b0;
        wel  <= 1'b0;
      end else begin
        timer <= timer - 1'b1;
      end
    end else if (frame_end) begin
      if (nbytes == 3'd1 && word[7:0] == OP_WREN) wel <= 1'b1;
      if (nbytes == 3'd1 && word[7:0] == OP_WRDI) wel <= 1'b0;
      if (nbytes == 3'd4 && word[31:24] == OP_ERASE && wel && !prot_hit) begin
        busy  <= 1'b1;
        timer <= TW'(ERASE_CYCLES - 1);
        blk   <= tgt_blk;
      end
    end
  end

  assign miso      = out_sh[7];
  assign miso_oe   = cs_act && rdsr_phase;
  assign erase_req = busy;
  assign erase_blk = blk;

  assert_start_needs_wel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));
  assert_start_unprotected_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(prot_hit));
  assert_start_on_32_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(nbytes == 3'd4 && bitcnt == 3'd0 && cs_rise));
  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && timer != '0) |=> busy);
  assert_wel_cleared_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  assert_state_frozen_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(wel) && $stable(blk)));
endmodule

// File: tb/tb_spi_blk_erase_ctl.sv
module tb_spi_blk_erase_ctl;
  localparam int EC = 3000;
  localparam int H  = 6;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, sclk = 0, mosi = 0;
  logic prot_cmp = 0, prot_tb = 0;
  logic [2:0] prot_bp = 0;
  logic miso, miso_oe, erase_req;
  logic [3:0] erase_blk;

  spi_blk_erase_ctl #(.ERASE_CYCLES(EC), .BLK_BITS(4)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .prot_cmp(prot_cmp), .prot_tb(prot_tb), .prot_bp(prot_bp),
    .miso(miso), .miso_oe(miso_oe), .erase_req(erase_req), .erase_blk(erase_blk));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  byte unsigned exp_q[$];
  string tag_q[$];
  int run_len = 0, last_len = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: assembles status bytes and compares with scoreboard queue
  byte unsigned mon_b = 0;
  int mon_n = 0;
  always @(posedge sclk) begin
    if (miso_oe) begin
      mon_b = {mon_b[6:0], miso};
      mon_n++;
      if (mon_n == 8) begin
        mon_n = 0;
        if (exp_q.size() == 0) chk(0, "R3", "unexpected status byte", mon_b, 0);
        else begin
          byte unsigned e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(mon_b == e, t, "status byte", mon_b, e);
        end
      end
    end
  end
  always @(posedge cs_n) mon_n = 0;

  always @(negedge clk) begin
    if (erase_req) run_len++;
    else if (run_len != 0) begin
      last_len = run_len;
      run_len = 0;
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(logic [63:0] data, int nbits, bit mode3);
    sclk = mode3;
    wait_clk(H);
    cs_n = 0;
    wait_clk(H);
    for (int i = 0; i < nbits; i++) begin
      sclk = 0;
      mosi = data[63-i];
      wait_clk(H);
      sclk = 1;
      wait_clk(H);
    end
    if (!mode3) sclk = 0;
    wait_clk(H);
    cs_n = 1;
    wait_clk(12);
  endtask

  task automatic cmd8(byte unsigned op, bit mode3);
    xfer({op, 56'h0}, 8, mode3);
  endtask

  task automatic rdsr(byte unsigned exp, int nb, bit mode3, string tag);
    for (int i = 0; i < nb; i++) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    xfer({8'h05, 56'h0}, 8 + 8 * nb, mode3);
    chk(exp_q.size() == 0, tag, "status bytes left unread", exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  task automatic erase(logic [23:0] addr, int nbits, bit mode3);
    xfer({8'hD8, addr, 32'h0}, nbits, mode3);
  endtask

  task automatic wait_done();
    while (erase_req) @(negedge clk);
    wait_clk(2);
    chk(last_len == EC, "R8", "busy length", last_len, EC);
  endtask

  initial begin
    fork
      begin
        wait_clk(4);
        rst_n = 1;
        wait_clk(4);
        chk(erase_req == 0, "R1", "erase_req after reset", erase_req, 0);
        chk(miso_oe == 0, "R1", "miso_oe after reset", miso_oe, 0);
        rdsr(8'h00, 1, 0, "R1");

        cmd8(8'h06, 0);
        rdsr(8'h02, 2, 0, "R2");
        cmd8(8'h04, 0);
        rdsr(8'h00, 1, 0, "R2");

        erase(24'h031234, 32, 0);
        chk(erase_req == 0, "R6", "erase without latch", erase_req, 0);

        cmd8(8'h06, 0);
        erase(24'h031234, 31, 0);
        chk(erase_req == 0, "R5", "erase on 31 bits", erase_req, 0);
        erase(24'h031234, 40, 0);
        chk(erase_req == 0, "R5", "erase on 40 bits", erase_req, 0);
        rdsr(8'h02, 1, 0, "R5");

        prot_bp = 3'd1; prot_tb = 0;
        erase(24'h0F0000, 32, 0);
        chk(erase_req == 0, "R7", "top block protected", erase_req, 0);
        rdsr(8'h02, 1, 0, "R7");

        erase(24'h0E1234, 32, 1);
        chk(erase_req == 1, "R4", "erase started mode 3 (R10)", erase_req, 1);
        chk(erase_blk == 4'hE, "R4", "erase block", erase_blk, 4'hE);
        rdsr(8'h03, 2, 0, "R9");
        cmd8(8'h04, 0);
        rdsr(8'h03, 1, 1, "R9");
        prot_bp = 0;
        erase(24'h050000, 32, 0);
        chk(erase_blk == 4'hE, "R9", "second erase ignored", erase_blk, 4'hE);
        wait_done();
        rdsr(8'h00, 1, 0, "R8");

        cmd8(8'h06, 1);
        rdsr(8'h02, 1, 1, "R10");
        prot_bp = 3'd2; prot_tb = 1; prot_cmp = 0;
        erase(24'h01FFFF, 32, 1);
        chk(erase_req == 0, "R7", "bottom block 1 protected", erase_req, 0);
        erase(24'h020000, 32, 0);
        chk(erase_req == 1, "R7", "block 2 free", erase_req, 1);
        chk(erase_blk == 4'h2, "R4", "erase block", erase_blk, 4'h2);
        wait_done();

        cmd8(8'h06, 0);
        prot_cmp = 1;
        erase(24'h050000, 32, 0);
        chk(erase_req == 0, "R7", "inverted region block 5", erase_req, 0);
        erase(24'h00ABCD, 32, 1);
        chk(erase_req == 1, "R7", "inverted region block 0", erase_req, 1);
        chk(erase_blk == 4'h0, "R4", "erase block", erase_blk, 4'h0);
        wait_done();
        rdsr(8'h00, 1, 1, "R8");
      end
      begin
        wait_clk(190000);
        chk(0, "R1", "watchdog expired", 0, 1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule